// File: doc/BRIEF.md
# Byte-Wide Single-Cycle Accumulator Core

This block is a small 8-bit processor core that completes one instruction on every clock. The program counter drives the instruction-memory address. The byte that comes back on the instruction-data input is decoded and executed at the next rising edge. The two top bits of the instruction pick one of four classes: load a small constant, run an ALU operation, copy between locations, or branch on a condition.

The core holds six general registers. Most of them have a fixed role. R0 receives constants and supplies the branch target. R1 and R2 are the ALU operands. R3 receives ALU results and is the value that branches test. A seventh location connects the core to the outside. Reading it samples the input byte. Writing it loads a registered output byte and raises a one-cycle valid strobe.

The core is meant to sit beside a combinational program store, such as a small ROM or a register array, and a simple byte-wide peripheral.

Top module: `cpu8_core`

## Requirements
- R1: While rst_n is low at a rising edge, the core clears the program counter, all six registers and out_data to zero, and out_valid to 0. After reset, imem_addr reads 0.
- R2: An instruction with bits [7:6] = 00 writes bits [5:0], zero-extended to 8 bits, into R0.
- R3: An instruction with bits [7:6] = 01 writes into R3 the bitwise operation on R1 and R2 that bits [2:0] select: 000 OR, 001 NAND, 010 NOR, 011 AND.
- R4: Under bits [7:6] = 01, code 100 writes R1 + R2 mod 256 into R3, and code 101 writes R1 - R2 mod 256 into R3.
- R5: An instruction with bits [7:6] = 10 copies the location named by bits [5:3] into the location named by bits [2:0]. Codes 0 to 5 name R0 to R5.
- R6: Under bits [7:6] = 10, source code 6 reads in_data. Destination code 6 loads out_data at that edge and holds out_valid high for exactly the following cycle.
- R7: Under bits [7:6] = 10, source code 7 reads as zero, so the copy clears its destination.
- R8: An instruction with bits [7:6] = 11 loads the program counter from R0 when R3, read as a signed two's-complement byte, meets the test in bits [2:0]: 000 never, 001 = 0, 010 < 0, 011 <= 0, 100 always, 101 != 0, 110 >= 0, 111 > 0.
- R9: Apart from a taken branch, every instruction advances the program counter by one, wrapping from 255 to 0.
- R10: ALU codes 110 and 111 and copy destination code 7 change no register, leave out_data unchanged and keep out_valid low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every instruction completes at a rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| imem_addr | output | 8 | Program counter, used as the instruction-memory address |
| imem_data | input | 8 | Instruction byte fetched from imem_addr |
| in_data | input | 8 | Input byte, read by copy source code 6 |
| out_data | output | 8 | Registered output byte, loaded by copy destination code 6 |
| out_valid | output | 1 | One-cycle strobe that follows each write to out_data |

## Verification
The embedded assertions check on every cycle that:
- the program counter steps by one, or lands on R0 after a taken branch;
- a constant load leaves the expected value in R0;
- a write to the output location produces the strobe and the data one cycle later;
- an instruction that writes nothing leaves every register stable.

Some behaviours can only be shown through the bench's scenarios, because registers are visible only by copying them to the output. These are the exact ALU results, including carry and borrow wrap, the eight branch tests against zero and sign boundary values of R3, the zero source, and the program-counter wrap from 255 to 0.

// File: rtl/cpu8_pkg.sv
// Package: shared encodings for the byte-wide core.
// Assumes an 8-bit instruction with the class held in the two top bits.
package cpu8_pkg;

    typedef enum logic [1:0] {
        CLS_IMM  = 2'b00,
        CLS_CALC = 2'b01,
        CLS_COPY = 2'b10,
        CLS_JUMP = 2'b11
    } cls_e;

    typedef enum logic [2:0] {
        OP_OR   = 3'd0,
        OP_NAND = 3'd1,
        OP_NOR  = 3'd2,
        OP_AND  = 3'd3,
        OP_ADD  = 3'd4,
        OP_SUB  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } alu_op_e;

    typedef enum logic [2:0] {
        JC_NEVER = 3'd0,
        JC_EQ    = 3'd1,
        JC_LT    = 3'd2,
        JC_LE    = 3'd3,
        JC_ALW   = 3'd4,
        JC_NE    = 3'd5,
        JC_GE    = 3'd6,
        JC_GT    = 3'd7
    } jcond_e;

    localparam int unsigned LOC_W     = 3;
    localparam logic [2:0]  LOC_PORT  = 3'd6;
    localparam logic [2:0]  LOC_ZERO  = 3'd7;

endpackage

// File: rtl/cpu8_alu.sv
// Module: cpu8_alu
// Combinational ALU for the calculate class: four bitwise operations,
// plus addition and subtraction, both truncated to W bits.
// Assumes the caller gates the register write with res_ok, which is low
// for the two reserved operation codes.
module cpu8_alu
    import cpu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  alu_op_e        op,
    input  logic [W-1:0]   opa,
    input  logic [W-1:0]   opb,
    output logic [W-1:0]   res,
    output logic           res_ok
);

    // Select the result for the requested operation.
    always_comb begin
        res    = '0;
        res_ok = 1'b1;
        unique case (op)
            OP_OR:   res = opa | opb;
            OP_NAND: res = ~(opa & opb);
            OP_NOR:  res = ~(opa | opb);
            OP_AND:  res = opa & opb;
            OP_ADD:  res = opa + opb;
            OP_SUB:  res = opa - opb;
            default: res_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu8_cond.sv
// Module: cpu8_cond
// Branch condition evaluator: tests a signed W-bit value against zero.
// Assumes two's complement, with the top bit as the sign.
module cpu8_cond
    import cpu8_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  jcond_e         cond,
    input  logic [W-1:0]   val,
    output logic           take
);

    logic is_zero;
    logic is_neg;

    // Derive the zero and sign flags of the tested value.
    always_comb begin
        is_zero = (val == '0);
        is_neg  = val[W-1];
    end

    // Map the condition code onto the flags.
    always_comb begin
        unique case (cond)
            JC_NEVER: take = 1'b0;
            JC_EQ:    take = is_zero;
            JC_LT:    take = is_neg;
            JC_LE:    take = is_neg | is_zero;
            JC_ALW:   take = 1'b1;
            JC_NE:    take = ~is_zero;
            JC_GE:    take = ~is_neg;
            JC_GT:    take = ~is_neg & ~is_zero;
            default:  take = 1'b0;
        endcase
    end

endmodule

// File: rtl/cpu8_regs.sv
// Module: cpu8_regs
// General register file with one write port, one indexed read port and
// four fixed-role taps (R0..R3). It also holds the output byte and its
// one-cycle valid strobe. Read codes at or above NREG select the input
// byte (LOC_PORT) or zero (any other code).
// Assumes NREG >= 4 and a synchronous, active-low reset.
module cpu8_regs
    import cpu8_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned NREG = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [LOC_W-1:0]   wr_sel,
    input  logic [W-1:0]       wr_val,
    input  logic               port_we,
    input  logic [LOC_W-1:0]   rd_sel,
    input  logic [W-1:0]       port_in,
    output logic [W-1:0]       rd_val,
    output logic [W-1:0]       tap_r0,
    output logic [W-1:0]       tap_r1,
    output logic [W-1:0]       tap_r2,
    output logic [W-1:0]       tap_r3,
    output logic [W-1:0]       port_out,
    output logic               port_vld
);

    logic [W-1:0] bank [NREG];

    genvar gi;
    generate
        for (gi = 0; gi < NREG; gi++) begin : g_reg
            // Hold or load one general register.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bank[gi] <= '0;
                else if (wr_en && (wr_sel == LOC_W'(gi)))
                    bank[gi] <= wr_val;
            end

            assert_hold_R10 : assert property (@(posedge clk) disable iff (!rst_n)
                !(wr_en && (wr_sel == LOC_W'(gi))) |=> $stable(bank[gi]))
                else $error("register %0d changed without a write", gi);
        end
    endgenerate

    // Indexed read: general registers, then the input port, then zero.
    always_comb begin
        if (32'(rd_sel) < NREG)
            rd_val = bank[rd_sel];
        else if (rd_sel == LOC_PORT)
            rd_val = port_in;
        else
            rd_val = '0;
    end

    // Expose the fixed-role registers.
    always_comb begin
        tap_r0 = bank[0];
        tap_r1 = bank[1];
        tap_r2 = bank[2];
        tap_r3 = bank[3];
    end

    // Output byte and its one-cycle strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            port_out <= '0;
            port_vld <= 1'b0;
        end else begin
            port_vld <= port_we;
            if (port_we)
                port_out <= wr_val;
        end
    end

    assert_strobe_R6 : assert property (@(posedge clk) disable iff (!rst_n)
        port_we |=> (port_vld && port_out == $past(wr_val)))
        else $error("output write not reflected");

    assert_quiet_R10 : assert property (@(posedge clk) disable iff (!rst_n)
        !port_we |=> (!port_vld && $stable(port_out)))
        else $error("output changed without a write");

endmodule

// File: rtl/cpu8_core.sv
// Module: cpu8_core
// Single-cycle byte-wide core. Each cycle it fetches imem_data from
// imem_addr (the program counter), decodes the class from bits [7:6] and
// commits at most one register or port write and the next PC at the edge.
// Assumes a combinational instruction store; W also sets the PC width,
// since branch targets come from R0.
module cpu8_core
    import cpu8_pkg::*;
#(
    parameter int unsigned W    = 8,
    parameter int unsigned NREG = 6
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [W-1:0]  imem_addr,
    input  logic [W-1:0]  imem_data,
    input  logic [W-1:0]  in_data,
    output logic [W-1:0]  out_data,
    output logic          out_valid
);

    localparam int unsigned IMM_W = W - 2;

    logic [W-1:0]     pc;
    cls_e             cls;
    logic [LOC_W-1:0] src_sel;
    logic [LOC_W-1:0] dst_sel;
    logic [W-1:0]     r0, r1, r2, r3;
    logic [W-1:0]     rd_val;
    logic [W-1:0]     alu_res;
    logic             alu_ok;
    logic             cond_hit;
    logic             take_jump;
    logic             wr_en;
    logic [LOC_W-1:0] wr_sel;
    logic [W-1:0]     wr_val;
    logic             port_we;

    // Split the instruction into class and location fields.
    always_comb begin
        cls     = cls_e'(imem_data[W-1 -: 2]);
        src_sel = imem_data[5:3];
        dst_sel = imem_data[2:0];
    end

    cpu8_alu #(.W(W)) u_alu (
        .op     (alu_op_e'(imem_data[2:0])),
        .opa    (r1),
        .opb    (r2),
        .res    (alu_res),
        .res_ok (alu_ok)
    );

    cpu8_cond #(.W(W)) u_cond (
        .cond (jcond_e'(imem_data[2:0])),
        .val  (r3),
        .take (cond_hit)
    );

    // Pick the single write this instruction performs, if any.
    always_comb begin
        wr_en   = 1'b0;
        wr_sel  = '0;
        wr_val  = '0;
        port_we = 1'b0;
        unique case (cls)
            CLS_IMM: begin
                wr_en  = 1'b1;
                wr_sel = LOC_W'(0);
                wr_val = {2'b00, imem_data[IMM_W-1:0]};
            end
            CLS_CALC: begin
                wr_en  = alu_ok;
                wr_sel = LOC_W'(3);
                wr_val = alu_res;
            end
            CLS_COPY: begin
                wr_en   = (32'(dst_sel) < NREG);
                wr_sel  = dst_sel;
                wr_val  = rd_val;
                port_we = (dst_sel == LOC_PORT);
            end
            default: ;
        endcase
    end

    cpu8_regs #(.W(W), .NREG(NREG)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_sel   (wr_sel),
        .wr_val   (wr_val),
        .port_we  (port_we),
        .rd_sel   (src_sel),
        .port_in  (in_data),
        .rd_val   (rd_val),
        .tap_r0   (r0),
        .tap_r1   (r1),
        .tap_r2   (r2),
        .tap_r3   (r3),
        .port_out (out_data),
        .port_vld (out_valid)
    );

    // Branch decision for this cycle.
    always_comb take_jump = (cls == CLS_JUMP) && cond_hit;

    // Program counter: branch target or next sequential address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pc <= '0;
        else if (take_jump)
            pc <= r0;
        else
            pc <= pc + 1'b1;
    end

    // Drive the fetch address.
    always_comb imem_addr = pc;

    assert_pc_step_R9 : assert property (@(posedge clk) disable iff (!rst_n)
        !take_jump |=> (pc == W'($past(pc) + 1'b1)))
        else $error("sequential PC step wrong");

    assert_jump_target_R8 : assert property (@(posedge clk) disable iff (!rst_n)
        take_jump |=> (pc == $past(r0)))
        else $error("taken branch missed R0 target");

    assert_imm_load_R2 : assert property (@(posedge clk) disable iff (!rst_n)
        (cls == CLS_IMM) |=> (r0 == {2'b00, $past(imem_data[IMM_W-1:0])}))
        else $error("constant load wrong");

endmodule

// File: tb/cpu8_core_test.sv
// Bench for cpu8_core. It drives instruction bytes straight onto imem_data,
// one per cycle, and watches out_data, out_valid and imem_addr.
module cpu8_core_test;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [7:0] imem_addr;
    logic [7:0] imem_data;
    logic [7:0] in_data;
    logic [7:0] out_data;
    logic       out_valid;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cpu8_core uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .imem_addr (imem_addr),
        .imem_data (imem_data),
        .in_data   (in_data),
        .out_data  (out_data),
        .out_valid (out_valid)
    );

    // ALU vectors: {op[2:0], a, b, expected}
    localparam logic [26:0] ALU_VEC [10] = '{
        {3'd0, 8'h0F, 8'hF0, 8'hFF},
        {3'd1, 8'hFF, 8'h0F, 8'hF0},
        {3'd2, 8'h0C, 8'h03, 8'hF0},
        {3'd3, 8'hAA, 8'h0F, 8'h0A},
        {3'd4, 8'hC8, 8'h64, 8'h2C},
        {3'd4, 8'h01, 8'h02, 8'h03},
        {3'd5, 8'h05, 8'h07, 8'hFE},
        {3'd5, 8'h80, 8'h01, 8'h7F},
        {3'd5, 8'h33, 8'h33, 8'h00},
        {3'd0, 8'h00, 8'h00, 8'h00}
    };

    localparam logic [7:0] NOP     = 8'hC0; // branch never
    localparam logic [7:0] IN_R1   = 8'hB1;
    localparam logic [7:0] IN_R2   = 8'hB2;
    localparam logic [7:0] IN_R3   = 8'hB3;
    localparam logic [7:0] IN_R0   = 8'hB0;
    localparam logic [7:0] R3_OUT  = 8'h9E;
    localparam logic [7:0] R0_OUT  = 8'h86;

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic step(input logic [7:0] ins);
        imem_data = ins;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit cond_ok(input logic [2:0] c, input logic [7:0] v);
        int s;
        s = $signed(v);
        case (c)
            3'd0: return 1'b0;
            3'd1: return s == 0;
            3'd2: return s < 0;
            3'd3: return s <= 0;
            3'd4: return 1'b1;
            3'd5: return s != 0;
            3'd6: return s >= 0;
            default: return s > 0;
        endcase
    endfunction

    initial begin
        rst_n     = 1'b0;
        imem_data = NOP;
        in_data   = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 pc", imem_addr, 8'h00);
        check("R1 out_data", out_data, 8'h00);
        check("R1 out_valid", {7'b0, out_valid}, 8'h00);
        rst_n = 1'b1;
        // R1: registers cleared, seen through copies to the output
        step(R0_OUT);
        check("R1 R0 zero", out_data, 8'h00);
        step(R3_OUT);
        check("R1 R3 zero", out_data, 8'h00);

        // R3/R4: table of ALU vectors
        foreach (ALU_VEC[i]) begin
            in_data = ALU_VEC[i][23:16];
            step(IN_R1);
            in_data = ALU_VEC[i][15:8];
            step(IN_R2);
            step({5'b01000, ALU_VEC[i][26:24]});
            step(R3_OUT);
            check(ALU_VEC[i][26:24] >= 3'd4 ? "R4 arith" : "R3 logic",
                  out_data, ALU_VEC[i][7:0]);
        end

        // R2: constant load, zero-extended
        step(8'h3F);
        step(R0_OUT);
        check("R2 imm 63", out_data, 8'h3F);
        // R6: strobe high for one cycle only
        check("R6 valid high", {7'b0, out_valid}, 8'h01);
        step(NOP);
        check("R6 valid drops", {7'b0, out_valid}, 8'h00);
        check("R6 data held", out_data, 8'h3F);

        // R6: input straight to output
        in_data = 8'hC3;
        step(8'hB6);
        check("R6 in to out", out_data, 8'hC3);

        // R5: chain R0 -> R4 -> R5 -> out
        step(8'h15);
        step(8'h84);
        step(8'hA5);
        step(8'hAE);
        check("R5 copy chain", out_data, 8'h15);

        // R7: zero source clears the destination
        in_data = 8'h99;
        step(8'hB4);
        step(8'hBC);
        step(8'hA6);
        check("R7 clear", out_data, 8'h00);

        // R10: reserved ALU codes and destination 7 write nothing
        in_data = 8'h5A;
        step(IN_R3);
        step(8'h46);
        step(8'h47);
        in_data = 8'h77;
        step(8'hB7);
        check("R10 dst7 no strobe", {7'b0, out_valid}, 8'h00);
        check("R10 dst7 out held", out_data, 8'h00);
        step(R3_OUT);
        check("R10 R3 kept", out_data, 8'h5A);

        // R8/R9: every condition against boundary values of R3
        step(8'h2A);
        foreach (ALU_VEC[k]) begin
            logic [7:0] v;
            if (k >= 5) break;
            v = (k == 0) ? 8'h00 : (k == 1) ? 8'h01 : (k == 2) ? 8'h80 :
                (k == 3) ? 8'h7F : 8'hFF;
            in_data = v;
            step(IN_R3);
            for (int c = 0; c < 8; c++) begin
                logic [7:0] prev;
                prev = imem_addr;
                step({5'b11000, 3'(c)});
                check(cond_ok(3'(c), v) ? "R8 taken" : "R9 not taken",
                      imem_addr, cond_ok(3'(c), v) ? 8'h2A : prev + 8'h01);
            end
        end

        // R9: wrap from 255 to 0
        in_data = 8'hFF;
        step(IN_R0);
        step(8'hC4);
        check("R8 jump to FF", imem_addr, 8'hFF);
        step(NOP);
        check("R9 wrap", imem_addr, 8'h00);

        // R1: reset mid-run clears state again
        rst_n = 1'b0;
        step(NOP);
        check("R1 re-reset pc", imem_addr, 8'h00);
        check("R1 re-reset out", out_data, 8'h00);
        rst_n = 1'b1;

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule